// File: doc/BRIEF.md
# DRAM Low-Power Mode Controller

This block decides when an attached DRAM leaves normal operation for one of its low-power states and when it comes back. It watches an idle indication from the command queue and programmable idle thresholds. It also takes two software request bits, a level request from a hardware power manager, and a select that names the memory family. From these it chooses among precharge power-down, clock stop, self-refresh and deep power-down.

Each state change is announced to the command generator as a one-cycle command request carrying a code. The current state is reported on a status output. After every exit, the block holds back new commands for a programmable recovery time and signals through a release output when commands may flow again. Self-refresh has three sources: software, an idle timeout counted from power-down entry, and the hardware handshake. The block remembers which source put the memory to sleep, because that source decides what wakes it.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the state output reads 0 (active), the release output is 1, and the command strobe, acknowledge and deny outputs are 0.
- R2: In the active state, once the queue has been idle on `pdIdleThr` consecutive clock edges, the block moves to power-down (state 1) and strobes code 1. A threshold of 0 disables this entry.
- R3: Clock stop (state 2, entry code 3) is taken from the active state after `csIdleThr` idle edges, but only when `memType` is 1 or 2 (the low-power families). With `memType` 0 it is never entered. When both thresholds are met on the same edge, power-down wins.
- R4: In power-down or clock stop, the self-refresh idle counter starts from zero. After `srIdleThr` further idle edges (0 disables it), the block enters self-refresh (state 3, code 5). A self-refresh entered this way exits (code 6) on the first edge that sees the queue busy.
- R5: In power-down or clock stop, a busy queue causes an exit: code 2 from power-down, code 4 from clock stop.
- R6: With `swSrReq` high and the queue idle, self-refresh is entered. While it lasts, traffic neither wakes the memory nor releases commands. It ends (code 6) only when `swSrReq` falls.
- R7: With `hwLpReq` high, an idle queue admits self-refresh, and `hwLpAck` stays high for as long as that stay lasts. A busy queue instead produces a registered `hwLpDeny` of 1 for each such edge. Dropping `hwLpReq` ends the stay (code 6). Acknowledge and deny are never high together.
- R8: Deep power-down (state 4, code 7) is entered only when `swDpdReq` is high, the queue is idle and `memType` is 1. It is left (code 8) only when `swDpdReq` falls. With any other `memType` the request has no effect.
- R9: After any exit command the state reads 5 (recovery) and release is 0. This lasts for max(`exitCycles`,1) cycles, after which the state returns to active with release 1.
- R10: When several entries are possible on one edge, the order of precedence is deep power-down, then software self-refresh, then hardware self-refresh, then the idle timers.
- R11: Every state change into or out of a low-power state is marked by exactly one cycle of `cmdValid` with the matching code, and `cmdValid` never fires without a state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| memType | input | 2 | Memory family: 0 DDR3-class, 1 LPDDR2, 2 LPDDR3 |
| queueIdle | input | 1 | High when the command queue holds no transaction |
| pdIdleThr | input | TW | Idle edges before power-down, 0 = off |
| csIdleThr | input | TW | Idle edges before clock stop, 0 = off |
| srIdleThr | input | TW | Idle edges in power-down/clock stop before self-refresh, 0 = off |
| exitCycles | input | EW | Recovery cycles after an exit |
| swSrReq | input | 1 | Software self-refresh request (level) |
| swDpdReq | input | 1 | Software deep power-down request (level) |
| hwLpReq | input | 1 | Hardware low-power request (level) |
| hwLpAck | output | 1 | High while self-refresh is held for the hardware request |
| hwLpDeny | output | 1 | Pulses when the hardware request meets a busy queue |
| cmdValid | output | 1 | One-cycle strobe for a state-change command |
| cmdCode | output | 4 | Command code: 1/2 power-down in/out, 3/4 clock stop in/out, 5/6 self-refresh in/out, 7/8 deep power-down in/out |
| lpState | output | 3 | 0 active, 1 power-down, 2 clock stop, 3 self-refresh, 4 deep power-down, 5 recovery |
| cmdRelease | output | 1 | High when new commands may be issued |

## Verification
A stale or wrong state register shows up on `lpState` and `cmdRelease` at the very next sampling point after the edge that should have moved it. It also shows up as a missing or extra code in the command stream, which the scoreboard catches at the cycle the strobe appears. A timer that is off by one is exposed by sampling the state one cycle before and exactly at each threshold. A wrongly remembered self-refresh source shows only later, when the wake condition arrives: software stays can be woken by traffic, and timeout stays can ignore it. The bench therefore applies traffic during each kind of stay and checks the state a few cycles after.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_PD     = 3'd1,
    ST_CS     = 3'd2,
    ST_SR     = 3'd3,
    ST_DPD    = 3'd4,
    ST_RECOV  = 3'd5
  } lpState_e;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_PD_IN   = 4'd1,
    CMD_PD_OUT  = 4'd2,
    CMD_CS_IN   = 4'd3,
    CMD_CS_OUT  = 4'd4,
    CMD_SR_IN   = 4'd5,
    CMD_SR_OUT  = 4'd6,
    CMD_DPD_IN  = 4'd7,
    CMD_DPD_OUT = 4'd8
  } lpCmd_e;

  typedef enum logic [1:0] {
    SRC_AUTO = 2'd0,
    SRC_SW   = 2'd1,
    SRC_HW   = 2'd2
  } srSrc_e;

  localparam logic [1:0] MEM_DDR3   = 2'd0;
  localparam logic [1:0] MEM_LPDDR2 = 2'd1;
  localparam logic [1:0] MEM_LPDDR3 = 2'd2;

  // strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic runIdle;   // active-state idle counter may count
    logic runSr;     // self-refresh idle counter may count
    logic runExit;   // recovery counter may count
  } ctlStrobes_t;

endpackage

// File: rtl/lpm_timers.sv
module lpm_timers
  import lpm_pkg::*;
#(
  parameter int TW = 12,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   ctl,
  input  logic          queueIdle,
  input  logic [TW-1:0] pdThr,
  input  logic [TW-1:0] csThr,
  input  logic [TW-1:0] srThr,
  input  logic [EW-1:0] exitCycles,
  output logic          pdHit,
  output logic          csHit,
  output logic          srHit,
  output logic          exitDone
);

  localparam int NFRONT = 2;   // power-down and clock stop share one idle counter

  logic [TW-1:0] idleCnt;
  logic [TW-1:0] srCnt;
  logic [EW-1:0] exitCnt;
  logic [TW:0]   idleNext;
  logic [TW:0]   srNext;
  logic [EW:0]   exitNext;
  logic [TW-1:0] frontThr [NFRONT];
  logic [NFRONT-1:0] frontHit;

  assign idleNext = {1'b0, idleCnt} + {{TW{1'b0}}, 1'b1};
  assign srNext   = {1'b0, srCnt}   + {{TW{1'b0}}, 1'b1};
  assign exitNext = {1'b0, exitCnt} + {{EW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (ctl.runIdle && queueIdle) begin
      if (idleCnt != '1) idleCnt <= idleNext[TW-1:0];
    end else begin
      idleCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srCnt <= '0;
    end else if (ctl.runSr && queueIdle) begin
      if (srCnt != '1) srCnt <= srNext[TW-1:0];
    end else begin
      srCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exitCnt <= '0;
    end else if (ctl.runExit) begin
      if (exitCnt != '1) exitCnt <= exitNext[EW-1:0];
    end else begin
      exitCnt <= '0;
    end
  end

  assign frontThr[0] = pdThr;
  assign frontThr[1] = csThr;

  for (genvar g = 0; g < NFRONT; g++) begin : g_front
    assign frontHit[g] = ctl.runIdle && queueIdle && (frontThr[g] != '0)
                         && (idleNext == {1'b0, frontThr[g]});
  end

  assign pdHit    = frontHit[0];
  assign csHit    = frontHit[1];
  assign srHit    = ctl.runSr && queueIdle && (srThr != '0)
                    && (srNext == {1'b0, srThr});
  assign exitDone = ctl.runExit && (exitNext >= {1'b0, exitCycles});

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  memType,
  input  logic        queueIdle,
  input  logic        swSrReq,
  input  logic        swDpdReq,
  input  logic        hwLpReq,
  input  logic        pdHit,
  input  logic        csHit,
  input  logic        srHit,
  input  logic        exitDone,
  output ctlStrobes_t ctl,
  output lpState_e    st,
  output logic        hwLpAck,
  output logic        hwLpDeny,
  output logic        cmdValid,
  output lpCmd_e      cmdCode
);

  srSrc_e   src, srcNext;
  lpState_e stNext;
  lpCmd_e   cmdNext;
  logic     denyNext;
  logic     csAllowed;
  logic     dpdAllowed;
  logic     frontState;

  assign csAllowed  = (memType == MEM_LPDDR2) || (memType == MEM_LPDDR3);
  assign dpdAllowed = (memType == MEM_LPDDR2);
  assign frontState = (st == ST_ACTIVE) || (st == ST_PD) || (st == ST_CS);

  always_comb begin
    stNext   = st;
    srcNext  = src;
    cmdNext  = CMD_NONE;
    denyNext = frontState && hwLpReq && !queueIdle;
    unique case (st)
      ST_ACTIVE, ST_PD, ST_CS: begin
        if (dpdAllowed && swDpdReq && queueIdle) begin
          stNext  = ST_DPD;
          cmdNext = CMD_DPD_IN;
        end else if (swSrReq && queueIdle) begin
          stNext  = ST_SR;
          srcNext = SRC_SW;
          cmdNext = CMD_SR_IN;
        end else if (hwLpReq && queueIdle) begin
          stNext  = ST_SR;
          srcNext = SRC_HW;
          cmdNext = CMD_SR_IN;
        end else if (!queueIdle) begin
          if (st != ST_ACTIVE) begin
            stNext  = ST_RECOV;
            cmdNext = (st == ST_PD) ? CMD_PD_OUT : CMD_CS_OUT;
          end
        end else if (st == ST_ACTIVE) begin
          if (pdHit) begin
            stNext  = ST_PD;
            cmdNext = CMD_PD_IN;
          end else if (csAllowed && csHit) begin
            stNext  = ST_CS;
            cmdNext = CMD_CS_IN;
          end
        end else if (srHit) begin
          stNext  = ST_SR;
          srcNext = SRC_AUTO;
          cmdNext = CMD_SR_IN;
        end
      end
      ST_SR: begin
        if ((src == SRC_SW   && !swSrReq) ||
            (src == SRC_HW   && !hwLpReq) ||
            (src == SRC_AUTO && !queueIdle)) begin
          stNext  = ST_RECOV;
          cmdNext = CMD_SR_OUT;
        end
      end
      ST_DPD: begin
        if (!swDpdReq) begin
          stNext  = ST_RECOV;
          cmdNext = CMD_DPD_OUT;
        end
      end
      ST_RECOV: begin
        if (exitDone) stNext = ST_ACTIVE;
      end
      default: stNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_ACTIVE;
      src      <= SRC_AUTO;
      cmdCode  <= CMD_NONE;
      cmdValid <= 1'b0;
      hwLpDeny <= 1'b0;
    end else begin
      st       <= stNext;
      src      <= srcNext;
      cmdCode  <= cmdNext;
      cmdValid <= (cmdNext != CMD_NONE);
      hwLpDeny <= denyNext;
    end
  end

  assign hwLpAck     = (st == ST_SR) && (src == SRC_HW);
  assign ctl.runIdle = (st == ST_ACTIVE);
  assign ctl.runSr   = (st == ST_PD) || (st == ST_CS);
  assign ctl.runExit = (st == ST_RECOV);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int TW = 12,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    memType,
  input  logic          queueIdle,
  input  logic [TW-1:0] pdIdleThr,
  input  logic [TW-1:0] csIdleThr,
  input  logic [TW-1:0] srIdleThr,
  input  logic [EW-1:0] exitCycles,
  input  logic          swSrReq,
  input  logic          swDpdReq,
  input  logic          hwLpReq,
  output logic          hwLpAck,
  output logic          hwLpDeny,
  output logic          cmdValid,
  output logic [3:0]    cmdCode,
  output logic [2:0]    lpState,
  output logic          cmdRelease
);

  ctlStrobes_t ctl;
  lpState_e    st;
  lpCmd_e      code;
  logic        pdHit, csHit, srHit, exitDone;

  lpm_timers #(.TW(TW), .EW(EW)) u_timers (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .queueIdle  (queueIdle),
    .pdThr      (pdIdleThr),
    .csThr      (csIdleThr),
    .srThr      (srIdleThr),
    .exitCycles (exitCycles),
    .pdHit      (pdHit),
    .csHit      (csHit),
    .srHit      (srHit),
    .exitDone   (exitDone)
  );

  lpm_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .memType   (memType),
    .queueIdle (queueIdle),
    .swSrReq   (swSrReq),
    .swDpdReq  (swDpdReq),
    .hwLpReq   (hwLpReq),
    .pdHit     (pdHit),
    .csHit     (csHit),
    .srHit     (srHit),
    .exitDone  (exitDone),
    .ctl       (ctl),
    .st        (st),
    .hwLpAck   (hwLpAck),
    .hwLpDeny  (hwLpDeny),
    .cmdValid  (cmdValid),
    .cmdCode   (code)
  );

  assign cmdCode    = code;
  assign lpState    = st;
  assign cmdRelease = (st == ST_ACTIVE);

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] memType,
  input logic       queueIdle,
  input logic       hwLpAck,
  input logic       hwLpDeny,
  input logic       cmdValid,
  input logic [3:0] cmdCode,
  input logic [2:0] lpState,
  input logic       cmdRelease
);

  assert_cs_family_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 3'd2) |-> (memType != 2'd0));

  assert_dpd_family_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 3'd4) |-> (memType == 2'd1));

  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hwLpAck) |-> $past(queueIdle));

  assert_ack_deny_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(hwLpAck && hwLpDeny));

  assert_cmd_on_change_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (lpState != $past(lpState)));

  assert_exit_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdCode[0]) |-> !cmdRelease);

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memType    (memType),
  .queueIdle  (queueIdle),
  .hwLpAck    (hwLpAck),
  .hwLpDeny   (hwLpDeny),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .lpState    (lpState),
  .cmdRelease (cmdRelease)
);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;

  localparam int TW = 12;
  localparam int EW = 6;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    memType;
  logic          queueIdle;
  logic [TW-1:0] pdIdleThr, csIdleThr, srIdleThr;
  logic [EW-1:0] exitCycles;
  logic          swSrReq, swDpdReq, hwLpReq;
  logic          hwLpAck, hwLpDeny, cmdValid, cmdRelease;
  logic [3:0]    cmdCode;
  logic [2:0]    lpState;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [3:0] expQ [$];

  always #2.5 clk = ~clk;

  lpm_ctrl #(.TW(TW), .EW(EW)) u_lpm_ctrl (
    .clk(clk), .rstN(rstN), .memType(memType), .queueIdle(queueIdle),
    .pdIdleThr(pdIdleThr), .csIdleThr(csIdleThr), .srIdleThr(srIdleThr),
    .exitCycles(exitCycles), .swSrReq(swSrReq), .swDpdReq(swDpdReq),
    .hwLpReq(hwLpReq), .hwLpAck(hwLpAck), .hwLpDeny(hwLpDeny),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .lpState(lpState),
    .cmdRelease(cmdRelease)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectCmd(input logic [3:0] c);
    expQ.push_back(c);
  endtask

  // monitor: every strobe must match the next expected command code (R11)
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R11: actual code %0d expected no command", cmdCode);
      end else begin
        logic [3:0] e;
        e = expQ.pop_front();
        if (e != cmdCode) begin
          fails++;
          $display("FAIL R11: actual code %0d expected %0d", cmdCode, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; memType = 2'd0; queueIdle = 1'b0;
    pdIdleThr = 12'd5; csIdleThr = 12'd3; srIdleThr = 12'd0; exitCycles = 6'd4;
    swSrReq = 1'b0; swDpdReq = 1'b0; hwLpReq = 1'b0;
    step(3);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 state", lpState, 0);
    chk("R1 release", cmdRelease, 1);
    chk("R1 ack", hwLpAck, 0);
    chk("R1 strobe", cmdValid, 0);

    // R2 power-down at threshold, R3 no clock stop for DDR3, R5/R9 exit
    queueIdle = 1'b1;
    expectCmd(4'd1);
    step(4);
    chk("R2 before threshold", lpState, 0);
    step(1);
    chk("R2 power-down entered", lpState, 1);
    queueIdle = 1'b0;
    expectCmd(4'd2);
    step(1);
    chk("R5 power-down exit", lpState, 5);
    chk("R9 release held", cmdRelease, 0);
    step(3);
    chk("R9 still recovering", lpState, 5);
    step(1);
    chk("R9 back to active", lpState, 0);
    chk("R9 release restored", cmdRelease, 1);

    // R3 clock stop on low-power family
    memType = 2'd2;
    queueIdle = 1'b1;
    expectCmd(4'd3);
    step(3);
    chk("R3 clock stop entered", lpState, 2);
    queueIdle = 1'b0;
    expectCmd(4'd4);
    step(1);
    chk("R5 clock stop exit", lpState, 5);
    step(4);
    chk("R5 active after clock stop", lpState, 0);

    // R4 idle-timeout self-refresh counted from power-down entry
    memType = 2'd0; pdIdleThr = 12'd2; srIdleThr = 12'd6; exitCycles = 6'd1;
    queueIdle = 1'b1;
    expectCmd(4'd1); expectCmd(4'd5);
    step(2);
    chk("R4 power-down first", lpState, 1);
    step(5);
    chk("R4 before sr threshold", lpState, 1);
    step(1);
    chk("R4 self-refresh entered", lpState, 3);
    queueIdle = 1'b0;
    expectCmd(4'd6);
    step(1);
    chk("R4 traffic wakes", lpState, 5);
    step(1);
    chk("R4 active", lpState, 0);

    // R6 software self-refresh
    pdIdleThr = 12'd0; srIdleThr = 12'd0;
    swSrReq = 1'b1;
    step(2);
    chk("R6 waits for idle queue", lpState, 0);
    queueIdle = 1'b1;
    expectCmd(4'd5);
    step(1);
    chk("R6 entered", lpState, 3);
    queueIdle = 1'b0;
    step(3);
    chk("R6 traffic ignored", lpState, 3);
    chk("R6 commands stalled", cmdRelease, 0);
    swSrReq = 1'b0;
    expectCmd(4'd6);
    step(1);
    chk("R6 exit on clear", lpState, 5);
    step(1);
    chk("R6 active", lpState, 0);

    // R7 hardware handshake
    hwLpReq = 1'b1;
    step(1);
    chk("R7 deny when busy", hwLpDeny, 1);
    chk("R7 no ack when busy", hwLpAck, 0);
    chk("R7 stays active", lpState, 0);
    queueIdle = 1'b1;
    expectCmd(4'd5);
    step(1);
    chk("R7 entered", lpState, 3);
    chk("R7 ack", hwLpAck, 1);
    chk("R7 deny dropped", hwLpDeny, 0);
    hwLpReq = 1'b0;
    expectCmd(4'd6);
    step(1);
    chk("R7 exit on drop", lpState, 5);
    chk("R7 ack released", hwLpAck, 0);
    step(1);

    // R8 deep power-down: ignored for DDR3 (also R2 threshold 0 disables)
    swDpdReq = 1'b1;
    step(3);
    chk("R8 ignored for DDR3", lpState, 0);
    chk("R2 disabled threshold", lpState, 0);
    swDpdReq = 1'b0;
    memType = 2'd1; csIdleThr = 12'd0;
    step(1);
    swDpdReq = 1'b1;
    expectCmd(4'd7);
    step(1);
    chk("R8 entered on LPDDR2", lpState, 4);
    queueIdle = 1'b0;
    step(2);
    chk("R8 traffic ignored", lpState, 4);
    swDpdReq = 1'b0;
    expectCmd(4'd8);
    step(1);
    chk("R8 exit", lpState, 5);
    step(1);
    chk("R8 active", lpState, 0);

    // R10 precedence
    queueIdle = 1'b1; swDpdReq = 1'b1; swSrReq = 1'b1; hwLpReq = 1'b1;
    expectCmd(4'd7);
    step(1);
    chk("R10 deep power-down first", lpState, 4);
    swDpdReq = 1'b0;
    expectCmd(4'd8); expectCmd(4'd5);
    step(2);
    chk("R10 recovered", lpState, 0);
    step(1);
    chk("R10 software beats hardware", lpState, 3);
    chk("R10 no hardware ack", hwLpAck, 0);
    swSrReq = 1'b0; hwLpReq = 1'b0; queueIdle = 1'b0;
    expectCmd(4'd6);
    step(2);
    chk("R10 active", lpState, 0);

    // R9 zero recovery count still gives one cycle
    memType = 2'd0; pdIdleThr = 12'd1; exitCycles = 6'd0;
    queueIdle = 1'b1;
    expectCmd(4'd1);
    step(1);
    chk("R2 threshold one", lpState, 1);
    queueIdle = 1'b0;
    expectCmd(4'd2);
    step(1);
    chk("R9 minimum recovery", lpState, 5);
    step(1);
    chk("R9 minimum recovery over", lpState, 0);

    step(2);
    chk("R11 all commands seen", expQ.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule